// File: doc/BRIEF.md
# Power-Gated Domain Sequencer

This block brings one switchable logic domain up and down in a safe order. On a power-on command it closes the domain's power switch under a current limit. It starts at the gentlest limit and raises the limit one step each time power-good fails to appear within a window. Once power is good, it removes electrical isolation and asks the domain's memories to repair themselves. It removes functional isolation only when the repair reports completion. If any of these steps times out, the block undoes what it has done, stage by stage, and raises an error pulse.

A power-off command unwinds the domain in the reverse order. The block also holds the domain's control word and presents it as one packed status vector. The power switch, the current limiter and the repair engine sit outside the block. All timeouts are counted in clock cycles. A base count sets them, and the power-good window is a multiple of that base.

Top module: `pgd_sequencer`

## Requirements
- R1: While reset is asserted and right after it, every control output is 0, `busy`, `done` and `error` are 0, and `ctrl_word` carries only the two input reflections.
- R2: `ctrl_word` is packed as follows. Bit 0 is the switch request. Bit 1 reflects `pwr_good`. Bit 2 is the electrical-isolation release. Bit 3 is the repair request. Bit 4 reflects `repair_done`. Bit 5 is the functional-isolation release. Bits 14:13 hold the inrush code. Every other bit is 0.
- R3: A power-on command that finds the switch request already set pulses `done` on the next cycle. It does not raise `busy` and changes no part of the control word.
- R4: An accepted power-on sets the switch request with inrush code 0, where codes 0 to 3 allow rising current. Each code is held for PG_WIN cycles without power-good before it moves one step up. Ramping stops at the first code where power-good is seen.
- R5: One cycle after power-good is seen, electrical isolation is released. One cycle after that, the repair request is raised. Functional isolation is released, together with a `done` pulse, in the cycle after repair-done is sampled.
- R6: If power-good is still absent at the end of the window at code 3, the switch request and the inrush code are cleared in the same cycle as an `error` pulse.
- R7: If repair-done is absent for REP_WIN cycles, electrical isolation is re-applied first. In the next cycle the switch request, the inrush code and the repair request clear, and `error` pulses.
- R8: Power-off applies functional isolation, then electrical isolation, then opens the switch and drops the repair request. Each step takes one cycle, and `done` pulses with the last step.
- R9: Commands that arrive while `busy` is high are ignored. When both commands arrive together while idle, power-on wins.
- R10: `done` and `error` are never high together. Each is a single-cycle pulse that ends a sequence. `busy` is high from the cycle after a command is accepted until the ending pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_on | input | 1 | Start power-on sequence |
| cmd_off | input | 1 | Start power-off sequence |
| pwr_good | input | 1 | Domain supply reported good |
| repair_done | input | 1 | Memory repair finished |
| sw_req | output | 1 | Power switch close request |
| inrush | output | 2 | Current-limit code, 0 lowest |
| iso_elec_rel | output | 1 | Electrical isolation released |
| repair_req | output | 1 | Memory repair request |
| iso_func_rel | output | 1 | Functional isolation released |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse: sequence finished |
| error | output | 1 | One-cycle pulse: sequence failed and rolled back |
| ctrl_word | output | 15 | Packed control/status word |

## Verification
Some properties are checked on every cycle. Functional isolation is never released while electrical isolation is applied, and electrical isolation is never released while the switch is open. While the switch stays closed, the inrush code only ever steps up by one. An error always leaves the switch open with the code at zero, and `done` and `error` never coincide. The exact cycle counts cannot be shown that way and need the bench scenarios. These cover how long each inrush code is held, when the isolation and repair steps happen, where the repair timeout sits relative to a late repair-done, and the rollback order. They also cover commands that must be ignored and the on-before-off priority.

// File: rtl/pgd_pkg.sv
package pgd_pkg;

    localparam int CW_W     = 15;
    localparam int B_PWRUP  = 0;
    localparam int B_PGOOD  = 1;
    localparam int B_ELEC   = 2;
    localparam int B_REP    = 3;
    localparam int B_RDONE  = 4;
    localparam int B_FUNC   = 5;
    localparam int B_INR_LO = 13;

    localparam logic [1:0] INRUSH_MAX = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_MEMREP,
        ST_REPAIR,
        ST_UNDO,
        ST_OFF_ELEC,
        ST_OFF_SW
    } seq_st_e;

    typedef struct packed {
        logic [1:0] inrush;
        logic       func_rel;
        logic       rep_req;
        logic       elec_rel;
        logic       pwr_up;
    } dom_ctl_t;

    function automatic int max_i(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [CW_W-1:0] pack_word(dom_ctl_t c, logic pg, logic rd);
        logic [CW_W-1:0] w;
        w                  = '0;
        w[B_PWRUP]         = c.pwr_up;
        w[B_PGOOD]         = pg;
        w[B_ELEC]          = c.elec_rel;
        w[B_REP]           = c.rep_req;
        w[B_RDONE]         = rd;
        w[B_FUNC]          = c.func_rel;
        w[B_INR_LO +: 2]   = c.inrush;
        return w;
    endfunction

endpackage

// File: rtl/pgd_timer.sv
module pgd_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (en)    cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/pgd_fsm.sv
module pgd_fsm
    import pgd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_on,
    input  logic     cmd_off,
    input  logic     pwr_good,
    input  logic     repair_done,
    input  logic     tmr_exp,
    output logic     tmr_clr,
    output logic     tmr_en,
    output logic     tmr_long,
    output dom_ctl_t ctl,
    output logic     busy,
    output logic     done,
    output logic     error
);
    seq_st_e  st_q, st_d;
    dom_ctl_t ctl_q, ctl_d;
    logic     done_q, done_d, err_q, err_d;

    always_comb begin
        st_d    = st_q;
        ctl_d   = ctl_q;
        done_d  = 1'b0;
        err_d   = 1'b0;
        tmr_clr = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_on) begin
                    if (ctl_q.pwr_up) begin
                        done_d = 1'b1;
                    end else begin
                        ctl_d.pwr_up = 1'b1;
                        ctl_d.inrush = '0;
                        tmr_clr      = 1'b1;
                        st_d         = ST_RAMP;
                    end
                end else if (cmd_off) begin
                    ctl_d.func_rel = 1'b0;
                    st_d           = ST_OFF_ELEC;
                end
            end
            ST_RAMP: begin
                if (pwr_good) begin
                    ctl_d.elec_rel = 1'b1;
                    st_d           = ST_MEMREP;
                end else if (tmr_exp) begin
                    if (ctl_q.inrush == INRUSH_MAX) begin
                        ctl_d.pwr_up = 1'b0;
                        ctl_d.inrush = '0;
                        err_d        = 1'b1;
                        st_d         = ST_IDLE;
                    end else begin
                        ctl_d.inrush = ctl_q.inrush + 2'd1;
                        tmr_clr      = 1'b1;
                    end
                end
            end
            ST_MEMREP: begin
                ctl_d.rep_req = 1'b1;
                tmr_clr       = 1'b1;
                st_d          = ST_REPAIR;
            end
            ST_REPAIR: begin
                if (repair_done) begin
                    ctl_d.func_rel = 1'b1;
                    done_d         = 1'b1;
                    st_d           = ST_IDLE;
                end else if (tmr_exp) begin
                    ctl_d.elec_rel = 1'b0;
                    st_d           = ST_UNDO;
                end
            end
            ST_UNDO: begin
                ctl_d.pwr_up  = 1'b0;
                ctl_d.inrush  = '0;
                ctl_d.rep_req = 1'b0;
                err_d         = 1'b1;
                st_d          = ST_IDLE;
            end
            ST_OFF_ELEC: begin
                ctl_d.elec_rel = 1'b0;
                st_d           = ST_OFF_SW;
            end
            ST_OFF_SW: begin
                ctl_d.pwr_up  = 1'b0;
                ctl_d.rep_req = 1'b0;
                done_d        = 1'b1;
                st_d          = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            ctl_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            ctl_q  <= ctl_d;
            done_q <= done_d;
            err_q  <= err_d;
        end
    end

    assign tmr_en   = (st_q == ST_RAMP) || (st_q == ST_REPAIR);
    assign tmr_long = (st_q == ST_RAMP);
    assign ctl      = ctl_q;
    assign busy     = (st_q != ST_IDLE);
    assign done     = done_q;
    assign error    = err_q;
endmodule

// File: rtl/pgd_sequencer.sv
module pgd_sequencer
    import pgd_pkg::*;
#(
    parameter int BASE_CYC = 50,
    parameter int PG_MULT  = 3,
    parameter int REP_MULT = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_on,
    input  logic            cmd_off,
    input  logic            pwr_good,
    input  logic            repair_done,
    output logic            sw_req,
    output logic [1:0]      inrush,
    output logic            iso_elec_rel,
    output logic            repair_req,
    output logic            iso_func_rel,
    output logic            busy,
    output logic            done,
    output logic            error,
    output logic [CW_W-1:0] ctrl_word
);
    localparam int PG_WIN  = BASE_CYC * PG_MULT;
    localparam int REP_WIN = BASE_CYC * REP_MULT;
    localparam int CNT_W   = $clog2(max_i(PG_WIN, REP_WIN) + 1);
    localparam logic [CNT_W-1:0] PG_LIM  = CNT_W'(PG_WIN);
    localparam logic [CNT_W-1:0] REP_LIM = CNT_W'(REP_WIN);

    dom_ctl_t ctl;
    logic     tmr_clr, tmr_en, tmr_long, tmr_exp;

    pgd_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (tmr_long ? PG_LIM : REP_LIM),
        .expired (tmr_exp)
    );

    pgd_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cmd_on      (cmd_on),
        .cmd_off     (cmd_off),
        .pwr_good    (pwr_good),
        .repair_done (repair_done),
        .tmr_exp     (tmr_exp),
        .tmr_clr     (tmr_clr),
        .tmr_en      (tmr_en),
        .tmr_long    (tmr_long),
        .ctl         (ctl),
        .busy        (busy),
        .done        (done),
        .error       (error)
    );

    assign sw_req       = ctl.pwr_up;
    assign inrush       = ctl.inrush;
    assign iso_elec_rel = ctl.elec_rel;
    assign repair_req   = ctl.rep_req;
    assign iso_func_rel = ctl.func_rel;
    assign ctrl_word    = pack_word(ctl, pwr_good, repair_done);
endmodule

// File: rtl/pgd_checker.sv
module pgd_checker (
    input logic       clk,
    input logic       rst,
    input logic       sw_req,
    input logic [1:0] inrush,
    input logic       iso_elec_rel,
    input logic       iso_func_rel,
    input logic       busy,
    input logic       done,
    input logic       error
);
    a_r5_func_after_elec: assert property (@(posedge clk) disable iff (rst)
        iso_func_rel |-> iso_elec_rel);

    a_r8_elec_needs_switch: assert property (@(posedge clk) disable iff (rst)
        iso_elec_rel |-> sw_req);

    a_r4_inrush_steps_up: assert property (@(posedge clk) disable iff (rst)
        (sw_req && $past(sw_req) && inrush != $past(inrush)) |-> (inrush == $past(inrush) + 2'd1));

    a_r6_error_leaves_off: assert property (@(posedge clk) disable iff (rst)
        error |-> (!sw_req && inrush == 2'd0 && !iso_elec_rel));

    a_r10_done_error_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    a_r10_end_pulse_idle: assert property (@(posedge clk) disable iff (rst)
        (done || error) |-> !busy);
endmodule

bind pgd_sequencer pgd_checker u_pgd_checker (
    .clk          (clk),
    .rst          (rst),
    .sw_req       (sw_req),
    .inrush       (inrush),
    .iso_elec_rel (iso_elec_rel),
    .iso_func_rel (iso_func_rel),
    .busy         (busy),
    .done         (done),
    .error        (error)
);

// File: tb/pgd_sequencer_bench.sv
module pgd_sequencer_bench;
    localparam int BASE  = 4;
    localparam int PG    = 3 * BASE;
    localparam int REP   = BASE;
    localparam int NEVER = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_on = 1'b0, cmd_off = 1'b0, pwr_good = 1'b0, repair_done = 1'b0;
    logic sw_req, iso_elec_rel, repair_req, iso_func_rel, busy, done, error;
    logic [1:0]  inrush;
    logic [14:0] ctrl_word;

    int n_chk = 0;
    int n_bad = 0;
    int good_from = 9;
    int rep_delay = NEVER;
    int rep_cnt = 0;

    always #10 clk = ~clk;

    pgd_sequencer #(.BASE_CYC(BASE), .PG_MULT(3), .REP_MULT(1)) u_pgd_sequencer (
        .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmd_off(cmd_off),
        .pwr_good(pwr_good), .repair_done(repair_done),
        .sw_req(sw_req), .inrush(inrush), .iso_elec_rel(iso_elec_rel),
        .repair_req(repair_req), .iso_func_rel(iso_func_rel),
        .busy(busy), .done(done), .error(error), .ctrl_word(ctrl_word)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // responders: supply and repair engine models
    task automatic respond();
        pwr_good = sw_req && (int'(inrush) >= good_from);
        if (repair_req) begin
            repair_done = (rep_cnt >= rep_delay);
            rep_cnt++;
        end else begin
            repair_done = 1'b0;
            rep_cnt = 0;
        end
    endtask

    function automatic int word_of(int sw, int pg, int el, int rq, int rd, int fn, int ir);
        return (ir << 13) | (fn << 5) | (rd << 4) | (rq << 3) | (el << 2) | (pg << 1) | sw;
    endfunction

    task automatic do_on(int g, int rd, bit poke_off, bit both);
        int t_end = -1, t_elec = -1, t_rep = -1, t_elec_off = -1, end_done = 0, busy_bad = 0;
        int e_end, e_elec, e_rep, e_done, e_sw, e_ir, e_el, e_rq, e_fn;
        string tag;
        tag = $sformatf("g=%0d rd=%0d", g, rd);
        good_from = g; rep_delay = rd; rep_cnt = 0;
        @(negedge clk);
        cmd_on = 1'b1; cmd_off = both;
        for (int n = 1; n < 200; n++) begin
            @(negedge clk);
            cmd_on = 1'b0;
            cmd_off = (poke_off && n == 3);
            if (n == 1 && both) chk("R9", {tag, " on wins over off"}, int'(sw_req), 1);
            if (iso_elec_rel && t_elec < 0) t_elec = n;
            if (repair_req && t_rep < 0) t_rep = n;
            if (t_elec > 0 && !iso_elec_rel && t_elec_off < 0) t_elec_off = n;
            if (t_end > 0) begin
                chk("R10", {tag, " pulse width"}, int'(done | error), 0);
                respond();
                break;
            end
            if (done || error) begin
                t_end = n; end_done = int'(done);
                if (busy) busy_bad++;
                if (g > 3) begin e_sw=0; e_ir=0; e_el=0; e_rq=0; e_fn=0; end
                else if (rd <= REP - 1) begin e_sw=1; e_ir=g; e_el=1; e_rq=1; e_fn=1; end
                else begin e_sw=0; e_ir=0; e_el=0; e_rq=0; e_fn=0; end
                chk("R2", {tag, " ctrl_word"}, int'(ctrl_word),
                    word_of(e_sw, int'(pwr_good), e_el, e_rq, int'(repair_done), e_fn, e_ir));
                chk("R6", {tag, " final switch"}, int'(sw_req), e_sw);
                chk("R4", {tag, " final inrush"}, int'(inrush), e_ir);
                chk("R7", {tag, " final repair req"}, int'(repair_req), e_rq);
            end else if (!busy) busy_bad++;
            respond();
        end
        chk("R10", {tag, " busy window"}, busy_bad, 0);
        if (g > 3) begin
            e_end = 4 * PG + 1; e_done = 0; e_elec = -1; e_rep = -1;
            chk("R6", {tag, " error time"}, t_end, e_end);
        end else begin
            e_elec = g * PG + 2; e_rep = g * PG + 3;
            chk("R4", {tag, " elec release time"}, t_elec, e_elec);
            chk("R5", {tag, " repair req time"}, t_rep, e_rep);
            if (rd <= REP - 1) begin
                e_end = g * PG + 4 + rd; e_done = 1;
                chk("R5", {tag, " done time"}, t_end, e_end);
            end else begin
                e_end = g * PG + 4 + REP; e_done = 0;
                chk("R7", {tag, " isolation reapplied"}, t_elec_off, g * PG + 3 + REP);
                chk("R7", {tag, " error time"}, t_end, e_end);
            end
        end
        chk(poke_off ? "R9" : "R10", {tag, " done vs error"}, end_done, e_done);
    endtask

    task automatic do_off();
        @(negedge clk);
        cmd_off = 1'b1;
        @(negedge clk); cmd_off = 1'b0;
        chk("R8", "off step1 func", int'(iso_func_rel), 0);
        chk("R8", "off step1 elec", int'(iso_elec_rel), 1);
        respond();
        @(negedge clk);
        chk("R8", "off step2 elec", int'(iso_elec_rel), 0);
        chk("R8", "off step2 switch", int'(sw_req), 1);
        respond();
        @(negedge clk);
        chk("R8", "off step3 switch", int'(sw_req), 0);
        chk("R8", "off step3 repair", int'(repair_req), 0);
        chk("R8", "off step3 done", int'(done), 1);
        respond();
        @(negedge clk);
        chk("R10", "off after done", int'(done | busy), 0);
        respond();
    endtask

    task automatic do_already_on();
        int w0;
        @(negedge clk);
        w0 = int'(ctrl_word);
        cmd_on = 1'b1;
        @(negedge clk); cmd_on = 1'b0;
        chk("R3", "already-on done", int'(done), 1);
        chk("R3", "already-on busy", int'(busy), 0);
        chk("R3", "already-on word", int'(ctrl_word), w0);
        respond();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset word", int'(ctrl_word), 0);
        chk("R1", "reset busy", int'(busy | done | error), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "after reset outputs",
            int'({sw_req, inrush, iso_elec_rel, repair_req, iso_func_rel}), 0);

        do_on(0, 0, 1'b0, 1'b0);
        do_already_on();
        do_off();

        for (int g = 0; g <= 4; g++) begin
            for (int k = 0; k < 4; k++) begin
                int rd;
                rd = (k == 0) ? 0 : (k == 1) ? REP - 1 : (k == 2) ? REP : NEVER;
                do_on(g, rd, 1'b0, 1'b0);
                if (g <= 3 && rd <= REP - 1) do_off();
            end
        end

        do_on(2, 1, 1'b1, 1'b1);
        do_off();

        summary();
        $finish;
    end
endmodule